// File: doc/BRIEF.md
# Register-Mapped Packet Stream Bridge

This block sits on a simple 32-bit register port and moves whole packets between software and two stream ports. On the send side, software stores words one at a time and then writes the packet's byte count. That count write commits the packet, and the block then plays it out on the stream master with `tx_tlast` marking the final word. On the receive side, the stream slave stores incoming beats. When a beat carries `rx_tlast`, the block queues the packet's byte count and destination. Software then takes each packet by reading its byte count once and its words one by one.

A 13-bit event register occupies bits 31..19 of offset 0x00 and is cleared by writing ones. An enable register at 0x04 masks it onto a single interrupt line. The block has three flush commands, one for the send side, one for the receive side and one for the whole core. Each acts only when the written word is exactly 0x000000A5.

The send engine has two states. In T_IDLE it waits until committed words exist (T_IDLE→T_SEND), and it returns when the beat carrying `tx_tlast` is accepted (T_SEND→T_IDLE). The receive read engine also has two states. In R_IDLE a successful byte-count read opens the oldest complete packet (R_IDLE→R_DRAIN). The data read that takes that packet's last word closes it (R_DRAIN→R_IDLE). A flush forces either engine back to its idle state.

Top module: `pkt_stream_bridge`

## Requirements
- R1: Byte offsets are as follows. Read-only: 0x0C send vacancy, 0x1C receive occupancy, 0x20 receive data, 0x24 receive byte count, 0x30 receive destination. Written: 0x10 send data, 0x14 send byte count, 0x08/0x18/0x28 flushes. Read and written: 0x00 events, 0x04 enables, 0x2C send destination. Bits 18..0 of the event register always read 0.
- R2: A write of exactly 0x000000A5 to 0x08 or 0x18 empties only that side and sets event bit 24 (send flush done) or 23 (receive flush done). The same value at 0x28 does both and also zeroes the enable and send-destination registers. Any other value written to these offsets changes nothing.
- R3: Writing a 1 to an event bit clears it. Bits written with 0 keep their value, and an event arriving in the same cycle wins.
- R4: `irq` is high exactly when some event bit is set whose enable bit is also set.
- R5: After N words are written to 0x10 and then 4*N to 0x14, the N words leave on the stream master in order. `tx_tlast` is high only on the Nth word. Data is held while `tx_tready` is low, and event bit 27 is set when the final beat is accepted.
- R6: If the byte count is 0, is not a multiple of 4, or is not four times the words written since the last commit, event bit 25 is set and those words are discarded. Vacancy then returns to its former value and nothing is sent.
- R7: Vacancy reads TX_DEPTH-4 minus the stored words. A data write while vacancy is 0 is dropped and sets event bit 28.
- R8: Occupancy counts the words of fully received packets not yet read. A byte-count read returns 4 times the oldest packet's words, and the following data reads return its words in order. Event bit 26 is set when a beat carrying `rx_tlast` is accepted.
- R9: A data read with no open packet returns 0, removes nothing and sets event bit 30.
- R10: A byte-count read while a packet is still open returns 0, sets event bit 31 and leaves the open packet's remaining words readable.
- R11: A byte-count read with no complete packet queued returns 0 and sets event bit 29. Words of a packet still arriving do not count as a queued packet.
- R12: Bits 22/21 are set in every cycle that send-side storage is at least TX_PF words or at most TX_PE words. Bits 20/19 are set on the same rules against RX_PF and RX_PE for receive-side storage.
- R13: The 0x2C register drives `tx_tdest`. Offset 0x30 returns the `rx_tdest` value carried by the last beat of the currently open packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| reg_addr | input | 6 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| tx_tvalid | output | 1 | Send stream valid |
| tx_tready | input | 1 | Send stream ready |
| tx_tdata | output | 32 | Send stream data |
| tx_tlast | output | 1 | Final word of a send packet |
| tx_tdest | output | DEST_W | Send destination |
| rx_tvalid | input | 1 | Receive stream valid |
| rx_tready | output | 1 | Receive stream ready |
| rx_tdata | input | 32 | Receive stream data |
| rx_tlast | input | 1 | Final word of a receive packet |
| rx_tdest | input | DEST_W | Receive destination |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases:

- **Byte-count mismatch.** A design that kept the uncommitted words would either send a stale word in front of the next packet or report lower vacancy afterwards.
- **Write into a full send store.** A design that wrapped the store would corrupt the final word of the committed packet.
- **Misordered receive reads.** These are the under-read and over-read cases. A design that popped anyway would lose the rest of the open packet.
- **Byte-count read with no complete packet.** While a half-arrived packet sits in storage, a design that counted raw storage would report nonzero occupancy.
- **Wrong flush key.** The bench writes 0x5A and 0x1A5 to the flush offsets. A design that decoded only the low byte, or any write, would empty the store.

// File: rtl/psb_pkg.sv
package psb_pkg;
    localparam int ST_W   = 13;
    localparam int ST_LSB = 19;

    // event bit indices inside the 13-bit event vector (bit 12 = register bit 31)
    localparam int B_RUNDERREAD = 12;
    localparam int B_ROVERREAD  = 11;
    localparam int B_RUNDERRUN  = 10;
    localparam int B_TOVERRUN   = 9;
    localparam int B_TDONE      = 8;
    localparam int B_RDONE      = 7;
    localparam int B_TMISMATCH  = 6;
    localparam int B_TFLUSHED   = 5;
    localparam int B_RFLUSHED   = 4;
    localparam int B_TPFULL     = 3;
    localparam int B_TPEMPTY    = 2;
    localparam int B_RPFULL     = 1;
    localparam int B_RPEMPTY    = 0;

    localparam logic [31:0] FLUSH_KEY = 32'h0000_00A5;

    localparam logic [5:0] A_EVT   = 6'h00;
    localparam logic [5:0] A_ENA   = 6'h04;
    localparam logic [5:0] A_TFLSH = 6'h08;
    localparam logic [5:0] A_TVAC  = 6'h0C;
    localparam logic [5:0] A_TDAT  = 6'h10;
    localparam logic [5:0] A_TLEN  = 6'h14;
    localparam logic [5:0] A_RFLSH = 6'h18;
    localparam logic [5:0] A_ROCC  = 6'h1C;
    localparam logic [5:0] A_RDAT  = 6'h20;
    localparam logic [5:0] A_RLEN  = 6'h24;
    localparam logic [5:0] A_CFLSH = 6'h28;
    localparam logic [5:0] A_TDST  = 6'h2C;
    localparam logic [5:0] A_RDST  = 6'h30;

    typedef enum logic {T_IDLE, T_SEND}  tx_state_e;
    typedef enum logic {R_IDLE, R_DRAIN} rx_state_e;
endpackage

// File: rtl/psb_fifo.sv
module psb_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else if (clr) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push && !full) wp <= wp + 1'b1;
            if (pop && !empty) rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !clr) mem[wp[AW-1:0]] <= din;
    end

    always_comb begin
        count = wp - rp;
        full  = (count == (AW+1)'(DEPTH));
        empty = (count == '0);
        dout  = mem[rp[AW-1:0]];
    end

    // R8
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !clr |-> !full);
endmodule

// File: rtl/psb_tx.sv
module psb_tx
    import psb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_word,
    input  logic [31:0]             wdata,
    input  logic                    launch,
    input  logic [31:0]             len_bytes,
    input  logic                    tready,
    output logic                    tvalid,
    output logic [31:0]             tdata,
    output logic                    tlast,
    output logic [$clog2(DEPTH):0]  occ,
    output logic [$clog2(DEPTH):0]  vacancy,
    output logic                    ev_overrun,
    output logic                    ev_mismatch,
    output logic                    ev_done
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] LIM = (AW+1)'(DEPTH - 4);

    logic [32:0] mem [DEPTH];   // {last, data}
    logic [AW:0] wp, cm, rp, pend, wp_m1;
    logic        accept, len_ok, commit, pop;
    tx_state_e   state_q, state_d;

    always_comb begin
        occ     = wp - rp;
        pend    = wp - cm;
        wp_m1   = wp - 1'b1;
        vacancy = (occ >= LIM) ? '0 : LIM - occ;
        accept  = wr_word && (vacancy != '0);
        len_ok  = (len_bytes[1:0] == 2'b00) && (len_bytes[31:2] == 30'(pend)) && (pend != '0);
        commit  = launch && len_ok;
        pop     = (state_q == T_SEND) && tready;
        ev_overrun  = wr_word && (vacancy == '0) && !clr;
        ev_mismatch = launch && !len_ok && !clr;
        ev_done     = pop && mem[rp[AW-1:0]][32] && !clr;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE: if (rp != cm) state_d = T_SEND;
            T_SEND: if (tready && mem[rp[AW-1:0]][32]) state_d = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= T_IDLE;
        else if (clr) state_q <= T_IDLE;
        else          state_q <= state_d;
    end

    // output process
    always_comb begin
        tvalid = (state_q == T_SEND);
        tdata  = mem[rp[AW-1:0]][31:0];
        tlast  = (state_q == T_SEND) && mem[rp[AW-1:0]][32];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0;
            cm <= '0;
            rp <= '0;
        end else if (clr) begin
            wp <= '0;
            cm <= '0;
            rp <= '0;
        end else begin
            if (accept)                wp <= wp + 1'b1;
            else if (launch && !len_ok) wp <= cm;
            if (commit)                cm <= wp;
            if (pop)                   rp <= rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (accept && !clr) mem[wp[AW-1:0]] <= {1'b0, wdata};
        if (commit && !clr) mem[wp_m1[AW-1:0]][32] <= 1'b1;
    end

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tvalid && !tready && !clr |=> tvalid && $stable(tdata) && $stable(tlast));
    // R7
    tx_occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= LIM);
    // R6
    tx_mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mismatch |=> (pend == '0));
endmodule

// File: rtl/psb_rx.sv
module psb_rx
    import psb_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int LQ_DEPTH = 4,
    parameter int DEST_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    tvalid,
    input  logic [31:0]             tdata,
    input  logic                    tlast,
    input  logic [DEST_W-1:0]       tdest,
    output logic                    tready,
    input  logic                    rd_len,
    input  logic                    rd_data,
    output logic [31:0]             len_val,
    output logic [31:0]             data_val,
    output logic [DEST_W-1:0]       cur_dest,
    output logic [$clog2(DEPTH):0]  occ,
    output logic [$clog2(DEPTH):0]  store_cnt,
    output logic                    ev_rc,
    output logic                    ev_overread,
    output logic                    ev_underread,
    output logic                    ev_underrun
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = DEST_W + AW + 1;
    localparam int LAW = $clog2(LQ_DEPTH);

    logic [31:0]       d_dout;
    logic              d_full, d_empty;
    logic [LW-1:0]     lq_din, lq_dout;
    logic [LAW:0]      lq_cnt;
    logic              lq_full, lq_empty;
    logic [AW:0]       wcnt, remain, done_q, lq_words;
    logic              beat, pkt_end, pop_len, pop_d;
    rx_state_e         state_q, state_d;

    psb_fifo #(.W(32), .DEPTH(DEPTH)) u_data (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(beat), .din(tdata), .pop(pop_d), .dout(d_dout),
        .count(store_cnt), .full(d_full), .empty(d_empty));

    psb_fifo #(.W(LW), .DEPTH(LQ_DEPTH)) u_lenq (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(pkt_end), .din(lq_din), .pop(pop_len), .dout(lq_dout),
        .count(lq_cnt), .full(lq_full), .empty(lq_empty));

    always_comb begin
        tready   = !d_full && !lq_full;
        beat     = tvalid && tready;
        pkt_end  = beat && tlast;
        lq_din   = {tdest, wcnt + 1'b1};
        lq_words = lq_dout[AW:0];
        pop_len  = rd_len && (state_q == R_IDLE) && !lq_empty && !clr;
        pop_d    = rd_data && (state_q == R_DRAIN) && !clr;
        ev_rc        = pkt_end && !clr;
        ev_underrun  = rd_len && (state_q == R_IDLE) && lq_empty && !clr;
        ev_underread = rd_len && (state_q == R_DRAIN) && !clr;
        ev_overread  = rd_data && (state_q == R_IDLE) && !clr;
        occ      = done_q;
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE:  if (pop_len) state_d = R_DRAIN;
            R_DRAIN: if (pop_d && remain == (AW+1)'(1)) state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= R_IDLE;
        else if (clr) state_q <= R_IDLE;
        else          state_q <= state_d;
    end

    // output process
    always_comb begin
        len_val  = (state_q == R_IDLE && !lq_empty) ? (32'(lq_words) << 2) : 32'd0;
        data_val = (state_q == R_DRAIN) ? d_dout : 32'd0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt     <= '0;
            remain   <= '0;
            done_q   <= '0;
            cur_dest <= '0;
        end else if (clr) begin
            wcnt     <= '0;
            remain   <= '0;
            done_q   <= '0;
            cur_dest <= '0;
        end else begin
            if (pkt_end)   wcnt <= '0;
            else if (beat) wcnt <= wcnt + 1'b1;
            if (pop_len) begin
                remain   <= lq_words;
                cur_dest <= lq_dout[LW-1:AW+1];
            end else if (pop_d) begin
                remain <= remain - 1'b1;
            end
            done_q <= done_q + (pkt_end ? wcnt + 1'b1 : '0) - (pop_d ? (AW+1)'(1) : '0);
        end
    end

    // R9
    rx_drain_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == R_DRAIN |-> !d_empty);
    // R8
    rx_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q <= store_cnt);
endmodule

// File: rtl/pkt_stream_bridge.sv
module pkt_stream_bridge
    import psb_pkg::*;
#(
    parameter int TX_DEPTH = 16,
    parameter int RX_DEPTH = 16,
    parameter int LQ_DEPTH = 4,
    parameter int DEST_W   = 4,
    parameter int TX_PF    = 10,
    parameter int TX_PE    = 2,
    parameter int RX_PF    = 12,
    parameter int RX_PE    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [5:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tx_tvalid,
    input  logic              tx_tready,
    output logic [31:0]       tx_tdata,
    output logic              tx_tlast,
    output logic [DEST_W-1:0] tx_tdest,
    input  logic              rx_tvalid,
    output logic              rx_tready,
    input  logic [31:0]       rx_tdata,
    input  logic              rx_tlast,
    input  logic [DEST_W-1:0] rx_tdest,
    output logic              irq
);
    localparam int TAW = $clog2(TX_DEPTH);
    localparam int RAW = $clog2(RX_DEPTH);

    logic [ST_W-1:0]   st_q, ena_q, st_set, st_clr;
    logic [DEST_W-1:0] tdest_q, rx_cur_dest;
    logic [TAW:0]      tx_occ, tx_vac;
    logic [RAW:0]      rx_occ, rx_cnt;
    logic [31:0]       rx_len_val, rx_data_val;
    logic              key, core_flush, tx_clr, rx_clr;
    logic              tx_ovr, tx_mis, tx_done;
    logic              rx_rc, rx_over, rx_under, rx_urun;

    always_comb begin
        key        = (reg_wdata == FLUSH_KEY);
        core_flush = reg_wr && reg_addr == A_CFLSH && key;
        tx_clr     = core_flush || (reg_wr && reg_addr == A_TFLSH && key);
        rx_clr     = core_flush || (reg_wr && reg_addr == A_RFLSH && key);
    end

    psb_tx #(.DEPTH(TX_DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .wr_word(reg_wr && reg_addr == A_TDAT), .wdata(reg_wdata),
        .launch(reg_wr && reg_addr == A_TLEN), .len_bytes(reg_wdata),
        .tready(tx_tready), .tvalid(tx_tvalid), .tdata(tx_tdata), .tlast(tx_tlast),
        .occ(tx_occ), .vacancy(tx_vac),
        .ev_overrun(tx_ovr), .ev_mismatch(tx_mis), .ev_done(tx_done));

    psb_rx #(.DEPTH(RX_DEPTH), .LQ_DEPTH(LQ_DEPTH), .DEST_W(DEST_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .tvalid(rx_tvalid), .tdata(rx_tdata), .tlast(rx_tlast), .tdest(rx_tdest),
        .tready(rx_tready),
        .rd_len(reg_rd && reg_addr == A_RLEN), .rd_data(reg_rd && reg_addr == A_RDAT),
        .len_val(rx_len_val), .data_val(rx_data_val), .cur_dest(rx_cur_dest),
        .occ(rx_occ), .store_cnt(rx_cnt),
        .ev_rc(rx_rc), .ev_overread(rx_over), .ev_underread(rx_under), .ev_underrun(rx_urun));

    always_comb begin
        st_set = '0;
        st_set[B_RUNDERREAD] = rx_under;
        st_set[B_ROVERREAD]  = rx_over;
        st_set[B_RUNDERRUN]  = rx_urun;
        st_set[B_TOVERRUN]   = tx_ovr;
        st_set[B_TDONE]      = tx_done;
        st_set[B_RDONE]      = rx_rc;
        st_set[B_TMISMATCH]  = tx_mis;
        st_set[B_TFLUSHED]   = tx_clr;
        st_set[B_RFLUSHED]   = rx_clr;
        st_set[B_TPFULL]     = 32'(tx_occ) >= 32'(TX_PF);
        st_set[B_TPEMPTY]    = 32'(tx_occ) <= 32'(TX_PE);
        st_set[B_RPFULL]     = 32'(rx_cnt) >= 32'(RX_PF);
        st_set[B_RPEMPTY]    = 32'(rx_cnt) <= 32'(RX_PE);
        st_clr = (reg_wr && reg_addr == A_EVT) ? reg_wdata[31:ST_LSB] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            ena_q   <= '0;
            tdest_q <= '0;
        end else begin
            st_q <= (st_q & ~st_clr) | st_set;
            if (core_flush) begin
                ena_q   <= '0;
                tdest_q <= '0;
            end else begin
                if (reg_wr && reg_addr == A_ENA)  ena_q   <= reg_wdata[31:ST_LSB];
                if (reg_wr && reg_addr == A_TDST) tdest_q <= reg_wdata[DEST_W-1:0];
            end
        end
    end

    always_comb begin
        case (reg_addr)
            A_EVT:   reg_rdata = {st_q, {ST_LSB{1'b0}}};
            A_ENA:   reg_rdata = {ena_q, {ST_LSB{1'b0}}};
            A_TVAC:  reg_rdata = 32'(tx_vac);
            A_ROCC:  reg_rdata = 32'(rx_occ);
            A_RDAT:  reg_rdata = rx_data_val;
            A_RLEN:  reg_rdata = rx_len_val;
            A_TDST:  reg_rdata = 32'(tdest_q);
            A_RDST:  reg_rdata = 32'(rx_cur_dest);
            default: reg_rdata = 32'd0;
        endcase
        tx_tdest = tdest_q;
        irq      = |(st_q & ena_q);
    end

    // R2
    tx_key_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clr |=> tx_vac == (TAW+1)'(TX_DEPTH - 4));
    // R2
    rx_key_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> rx_occ == '0);
    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_EVT && reg_wdata[ST_LSB + B_TDONE] && !tx_done
        |=> !st_q[B_TDONE]);
endmodule

// File: tb/pkt_stream_bridge_tb.sv
module pkt_stream_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [5:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        tx_tvalid, tx_tready, tx_tlast;
    logic [31:0] tx_tdata;
    logic [3:0]  tx_tdest;
    logic        rx_tvalid, rx_tready, rx_tlast;
    logic [31:0] rx_tdata;
    logic [3:0]  rx_tdest;
    logic        irq;

    int nchk = 0;
    int nfail = 0;
    logic [36:0] cap [$];   // {dest, last, data}

    localparam logic [31:0] M_UNDERREAD = 32'h8000_0000;
    localparam logic [31:0] M_OVERREAD  = 32'h4000_0000;
    localparam logic [31:0] M_UNDERRUN  = 32'h2000_0000;
    localparam logic [31:0] M_TOVERRUN  = 32'h1000_0000;
    localparam logic [31:0] M_TDONE     = 32'h0800_0000;
    localparam logic [31:0] M_RDONE     = 32'h0400_0000;
    localparam logic [31:0] M_MISMATCH  = 32'h0200_0000;
    localparam logic [31:0] M_TFLUSHED  = 32'h0100_0000;
    localparam logic [31:0] M_RFLUSHED  = 32'h0080_0000;
    localparam logic [31:0] M_TPFULL    = 32'h0040_0000;
    localparam logic [31:0] M_TPEMPTY   = 32'h0020_0000;
    localparam logic [31:0] M_RPFULL    = 32'h0010_0000;
    localparam logic [31:0] M_RPEMPTY   = 32'h0008_0000;

    always #2 clk = ~clk;

    pkt_stream_bridge u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tdata(tx_tdata),
        .tx_tlast(tx_tlast), .tx_tdest(tx_tdest),
        .rx_tvalid(rx_tvalid), .rx_tready(rx_tready), .rx_tdata(rx_tdata),
        .rx_tlast(rx_tlast), .rx_tdest(rx_tdest),
        .irq(irq));

    always @(negedge clk) begin
        if (rst_n && tx_tvalid && tx_tready) cap.push_back({tx_tdest, tx_tlast, tx_tdata});
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rx_pkt(input int n, input logic [31:0] base, input logic [3:0] d, input bit close);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rx_tvalid = 1'b1; rx_tdata = base + 32'(i); rx_tdest = d;
            rx_tlast = close && (i == n - 1);
            #1;
            while (!rx_tready) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        rx_tvalid = 1'b0; rx_tlast = 1'b0;
    endtask

    task automatic clear_all();
        wr(6'h00, 32'hFFF8_0000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        idle(3);
        rd(6'h00, v);
        chk("R1 reserved bits", v & 32'h0007_FFFF, 32'h0);
        chk("R12 idle levels", v & 32'h0078_0000, M_TPEMPTY | M_RPEMPTY);
        chk("R3 no events at reset", v & 32'hFF80_0000, 32'h0);
        rd(6'h0C, v); chk("R7 reset vacancy", v, 32'd12);
        rd(6'h1C, v); chk("R8 reset occupancy", v, 32'd0);
        chk("R4 irq at reset", 32'(irq), 32'd0);
    endtask

    task automatic t_tx();
        logic [31:0] v;
        cap.delete();
        tx_tready = 1'b0;
        wr(6'h2C, 32'd3);
        for (int i = 0; i < 3; i++) wr(6'h10, 32'hA000_0000 + 32'(i));
        rd(6'h0C, v); chk("R7 vacancy after 3 words", v, 32'd9);
        wr(6'h14, 32'd12);
        idle(5);
        chk("R5 valid under stall", 32'(tx_tvalid), 32'd1);
        chk("R5 data held under stall", tx_tdata, 32'hA000_0000);
        chk("R5 nothing taken under stall", 32'(cap.size()), 32'd0);
        tx_tready = 1'b1;
        idle(10);
        chk("R5 packet size", 32'(cap.size()), 32'd3);
        if (cap.size() == 3) begin
            for (int i = 0; i < 3; i++) begin
                chk("R5 word order", cap[i][31:0], 32'hA000_0000 + 32'(i));
                chk("R5 last flag", 32'(cap[i][32]), (i == 2) ? 32'd1 : 32'd0);
            end
            chk("R13 send destination", 32'(cap[0][36:33]), 32'd3);
        end
        rd(6'h00, v); chk("R5 send done event", v & M_TDONE, M_TDONE);
        wr(6'h00, M_TDONE);
        rd(6'h00, v);
        chk("R3 cleared by one", v & M_TDONE, 32'h0);
        chk("R3 zero bits kept", v & M_TPEMPTY, M_TPEMPTY);
    endtask

    task automatic t_mismatch();
        logic [31:0] v;
        cap.delete();
        clear_all();
        wr(6'h10, 32'hB000_0000);
        wr(6'h10, 32'hB000_0001);
        wr(6'h14, 32'd12);
        idle(5);
        rd(6'h00, v); chk("R6 mismatch event", v & M_MISMATCH, M_MISMATCH);
        chk("R6 nothing sent", 32'(cap.size()), 32'd0);
        rd(6'h0C, v); chk("R6 words discarded", v, 32'd12);
        wr(6'h10, 32'hC000_0000);
        wr(6'h14, 32'd4);
        idle(10);
        chk("R6 next packet alone", 32'(cap.size()), 32'd1);
        if (cap.size() == 1) chk("R6 next packet word", cap[0][31:0], 32'hC000_0000);
    endtask

    task automatic t_overrun();
        logic [31:0] v;
        cap.delete();
        clear_all();
        for (int i = 0; i < 12; i++) wr(6'h10, 32'hD000_0000 + 32'(i));
        rd(6'h0C, v); chk("R7 vacancy exhausted", v, 32'd0);
        wr(6'h10, 32'hEEEE_EEEE);
        rd(6'h00, v);
        chk("R7 overrun event", v & M_TOVERRUN, M_TOVERRUN);
        chk("R12 send full level", v & M_TPFULL, M_TPFULL);
        wr(6'h14, 32'd48);
        idle(30);
        chk("R7 committed count", 32'(cap.size()), 32'd12);
        if (cap.size() == 12) begin
            chk("R7 final word kept", cap[11][31:0], 32'hD000_000B);
            chk("R7 final last", 32'(cap[11][32]), 32'd1);
        end
    endtask

    task automatic t_irq();
        clear_all();
        wr(6'h04, M_TDONE);
        idle(1);
        chk("R4 masked level", 32'(irq), 32'd0);
        wr(6'h10, 32'h1234_5678);
        wr(6'h14, 32'd4);
        idle(10);
        chk("R4 enabled event", 32'(irq), 32'd1);
        wr(6'h00, M_TDONE);
        idle(1);
        chk("R4 after clear", 32'(irq), 32'd0);
        wr(6'h04, M_TPEMPTY);
        idle(1);
        chk("R4 level event enabled", 32'(irq), 32'd1);
        wr(6'h04, 32'h0);
    endtask

    task automatic t_rx();
        logic [31:0] v;
        clear_all();
        rx_pkt(3, 32'h100, 4'd5, 1'b1);
        rx_pkt(2, 32'h200, 4'd9, 1'b1);
        idle(2);
        rd(6'h1C, v); chk("R8 occupancy", v, 32'd5);
        rd(6'h00, v); chk("R8 receive event", v & M_RDONE, M_RDONE);
        rd(6'h24, v); chk("R8 first length", v, 32'd12);
        rd(6'h30, v); chk("R13 first dest", v, 32'd5);
        for (int i = 0; i < 3; i++) begin
            rd(6'h20, v); chk("R8 first words", v, 32'h100 + 32'(i));
        end
        rd(6'h24, v); chk("R8 second length", v, 32'd8);
        rd(6'h30, v); chk("R13 second dest", v, 32'd9);
        for (int i = 0; i < 2; i++) begin
            rd(6'h20, v); chk("R8 second words", v, 32'h200 + 32'(i));
        end
        rd(6'h1C, v); chk("R8 drained", v, 32'd0);
        rd(6'h20, v); chk("R9 over-read value", v, 32'd0);
        rd(6'h00, v); chk("R9 over-read event", v & M_OVERREAD, M_OVERREAD);
    endtask

    task automatic t_underread();
        logic [31:0] v;
        clear_all();
        rx_pkt(2, 32'h300, 4'd1, 1'b1);
        idle(2);
        rd(6'h24, v); chk("R10 length", v, 32'd8);
        rd(6'h20, v); chk("R10 first word", v, 32'h300);
        rd(6'h24, v); chk("R10 early length value", v, 32'd0);
        rd(6'h00, v); chk("R10 under-read event", v & M_UNDERREAD, M_UNDERREAD);
        rd(6'h20, v); chk("R10 word kept", v, 32'h301);
        rd(6'h00, v); chk("R9 no false over-read", v & M_OVERREAD, 32'h0);
    endtask

    task automatic t_underrun();
        logic [31:0] v;
        clear_all();
        rd(6'h24, v); chk("R11 empty length", v, 32'd0);
        rd(6'h00, v); chk("R11 underrun event", v & M_UNDERRUN, M_UNDERRUN);
        clear_all();
        rx_pkt(2, 32'h400, 4'd2, 1'b0);
        idle(2);
        rd(6'h1C, v); chk("R11 partial not counted", v, 32'd0);
        rd(6'h24, v); chk("R11 partial length", v, 32'd0);
        rd(6'h00, v); chk("R11 partial underrun", v & M_UNDERRUN, M_UNDERRUN);
    endtask

    task automatic t_keys();
        logic [31:0] v;
        clear_all();
        wr(6'h10, 32'h1);
        wr(6'h10, 32'h2);
        wr(6'h08, 32'h0000_005A);
        rd(6'h0C, v); chk("R2 wrong send key", v, 32'd10);
        rd(6'h00, v); chk("R2 no send flush event", v & M_TFLUSHED, 32'h0);
        wr(6'h08, 32'h0000_00A5);
        rd(6'h0C, v); chk("R2 send flushed", v, 32'd12);
        rd(6'h00, v); chk("R2 send flush event", v & M_TFLUSHED, M_TFLUSHED);
        rx_pkt(1, 32'h402, 4'd2, 1'b1);   // closes the partial packet: 3 words
        idle(2);
        rd(6'h1C, v); chk("R2 receive before flush", v, 32'd3);
        wr(6'h18, 32'h0000_01A5);
        rd(6'h1C, v); chk("R2 wrong receive key", v, 32'd3);
        rd(6'h00, v); chk("R2 no receive flush event", v & M_RFLUSHED, 32'h0);
        wr(6'h18, 32'h0000_00A5);
        rd(6'h1C, v); chk("R2 receive flushed", v, 32'd0);
        rd(6'h00, v); chk("R2 receive flush event", v & M_RFLUSHED, M_RFLUSHED);
        clear_all();
        wr(6'h04, M_MISMATCH);
        wr(6'h2C, 32'd7);
        wr(6'h28, 32'h0000_00A5);
        rd(6'h00, v); chk("R2 core flush events", v & (M_TFLUSHED | M_RFLUSHED), M_TFLUSHED | M_RFLUSHED);
        rd(6'h04, v); chk("R2 core flush enables", v, 32'h0);
        rd(6'h2C, v); chk("R2 core flush dest", v, 32'h0);
    endtask

    task automatic t_rx_levels();
        logic [31:0] v;
        rx_pkt(12, 32'h500, 4'd4, 1'b1);
        idle(2);
        clear_all();
        rd(6'h00, v);
        chk("R12 receive full level", v & M_RPFULL, M_RPFULL);
        chk("R12 receive empty level gone", v & M_RPEMPTY, 32'h0);
        wr(6'h18, 32'h0000_00A5);
    endtask

    initial begin
        #600000;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        tx_tready = 1'b1; rx_tvalid = 1'b0; rx_tdata = '0; rx_tlast = 1'b0; rx_tdest = '0;
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_tx();
        t_mismatch();
        t_overrun();
        t_irq();
        t_rx();
        t_underread();
        t_underrun();
        t_keys();
        t_rx_levels();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule